// File: doc/BRIEF.md
# Sequential Bit Scatter/Gather Unit

This block moves bits between a packed field and the scattered positions picked out by a mask. It supports two operations. In scatter (deposit), the low-order source bits are spread out to the set positions of the mask. In gather (extract), the source bits found at the set mask positions are collected into a contiguous field that starts at bit 0. Result bits that receive nothing are zero.

The unit is iterative. A working copy of the mask is held in a register. On each cycle a priority encoder picks the lowest set bit of that copy, one bit is moved, and the chosen bit is cleared from the copy. A separate counter tracks the position on the packed side. An operation therefore takes as many cycles as the mask has set bits, and never fewer than one. The caller pulses a start input and waits for a one-cycle done pulse. The result then stays on the output until the next accepted start.

Top module: `pdx_unit`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is all zeros.
- R2: With `op_i` = 0 (scatter), source bit k goes to the position of the k-th lowest set mask bit, counting from k = 0.
- R3: With `op_i` = 1 (gather), the source bit at the k-th lowest set mask position goes to result bit k, counting from k = 0.
- R4: Result bits that no step writes are 0. An all-zero mask gives an all-zero result for either operation, with a latency of one cycle.
- R5: Let the start pulse be sampled at clock edge E, and let L be the mask's population count, or 1 if that count is 0. Then `done_o` is high during the cycle that follows edge E+L.
- R6: `done_o` stays high for exactly one cycle per operation.
- R7: A start pulse that arrives while an operation is running is ignored. The running operation finishes with its own operands, operation and latency.
- R8: From the done pulse until the next accepted start, `result_o` does not change.
- R9: With an all-ones mask, both operations return the source unchanged after WIDTH cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| op_i | input | 1 | Operation select: 0 = scatter, 1 = gather |
| src_i | input | WIDTH | Source operand |
| mask_i | input | WIDTH | Selection mask |
| result_o | output | WIDTH | Result, valid from the done pulse onward |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the points where an iterative scatter/gather is most likely to go wrong:
- Sparse masks with alternating source data. A design that walks the mask from the top, or that uses the mask position as the packed index, returns bits in the wrong order.
- The zero mask and the all-ones mask. These expose an off-by-one in termination: an extra cycle, a missing bit, or a hung unit that never pulses done.
- A second start during a run. A unit that reloads on it returns the intruder's result or the wrong latency.
- Several idle cycles after done. These catch a done pulse that does not drop, and a result register that keeps changing or is cleared too early.

// File: rtl/pdx_pkg.sv
package pdx_pkg;

   typedef enum logic {
      PDX_SCATTER = 1'b0,
      PDX_GATHER  = 1'b1
   } pdx_op_e;

   typedef enum logic {
      PDX_IDLE = 1'b0,
      PDX_RUN  = 1'b1
   } pdx_state_e;

endpackage

// File: rtl/pdx_lowbit.sv
// Lowest-set-bit finder: binary index, presence flag and the vector with that bit removed.
module pdx_lowbit #(
   parameter int WIDTH = 32,
   parameter int IDX_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] vec_i,
   output logic [IDX_W-1:0] pos_o,
   output logic             any_o,
   output logic [WIDTH-1:0] rest_o
);

   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   function automatic logic [WIDTH-1:0] sel_mask(input int bitno);
      logic [WIDTH-1:0] m;
      for (int i = 0; i < WIDTH; i++) m[i] = ((i >> bitno) & 1) != 0;
      return m;
   endfunction

   logic [WIDTH-1:0] isolated;

   assign isolated = vec_i & (~vec_i + ONE);
   assign any_o    = |vec_i;
   assign rest_o   = vec_i & (vec_i - ONE);

   generate
      for (genvar b = 0; b < IDX_W; b++) begin : g_enc
         localparam logic [WIDTH-1:0] SEL = sel_mask(b);
         assign pos_o[b] = |(isolated & SEL);
      end
   endgenerate

   always_comb begin
      if (any_o) begin
         AST_POS_IS_SET: assert (vec_i[pos_o]);                          // R2
         AST_POS_IS_LOWEST: assert ((vec_i & ((ONE << pos_o) - ONE)) == '0); // R3
      end
   end

endmodule

// File: rtl/pdx_ctrl.sv
// Sequencer: idle/run state, packed-side index counter and the done pulse.
module pdx_ctrl
   import pdx_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             last_i,
   output logic             load_o,
   output logic             step_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [IDX_W-1:0] idx_o
);

   pdx_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic             done_q;
   logic             finish;

   assign busy_o = (state_q == PDX_RUN);
   assign load_o = !busy_o && start_i;
   assign step_o = busy_o;
   assign finish = busy_o && last_i;
   assign done_o = done_q;
   assign idx_o  = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PDX_IDLE;
         idx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= finish;
         if (load_o) begin
            state_q <= PDX_RUN;
            idx_q   <= '0;
         end else if (step_o) begin
            idx_q <= idx_q + 1'b1;
            if (last_i) state_q <= PDX_IDLE;
         end
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                                  // R6
   AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o && !last_i) |=> (idx_o == $past(idx_o) + 1'b1));              // R5
   AST_FINISH_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> (done_o && !busy_o));                                      // R5

endmodule

// File: rtl/pdx_bitmove.sv
// Chooses the bit to read and the result position to write for the selected operation.
module pdx_bitmove
   import pdx_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int IDX_W = $clog2(WIDTH)
) (
   input  pdx_op_e          op_i,
   input  logic [WIDTH-1:0] src_i,
   input  logic [IDX_W-1:0] mask_pos_i,
   input  logic [IDX_W-1:0] pack_idx_i,
   output logic             bit_o,
   output logic [IDX_W-1:0] wr_pos_o
);

   always_comb begin
      if (op_i == PDX_SCATTER) begin
         bit_o    = src_i[pack_idx_i];
         wr_pos_o = mask_pos_i;
      end else begin
         bit_o    = src_i[mask_pos_i];
         wr_pos_o = pack_idx_i;
      end
   end

endmodule

// File: rtl/pdx_unit.sv
// Top: operand registers, working mask, result register.
module pdx_unit
   import pdx_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             op_i,
   input  logic [WIDTH-1:0] src_i,
   input  logic [WIDTH-1:0] mask_i,
   output logic [WIDTH-1:0] result_o,
   output logic             done_o
);

   localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("pdx_unit: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] src_q, mask_q, res_q, rest;
   pdx_op_e          op_q;
   logic [IDX_W-1:0] pos, idx, wr_pos;
   logic             any, last, load, step, busy, mv_bit;

   pdx_lowbit #(.WIDTH(WIDTH), .IDX_W(IDX_W)) lowbit_i (
      .vec_i (mask_q),
      .pos_o (pos),
      .any_o (any),
      .rest_o(rest)
   );

   assign last = (rest == '0);

   pdx_ctrl #(.IDX_W(IDX_W)) ctrl_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_i),
      .last_i (last),
      .load_o (load),
      .step_o (step),
      .busy_o (busy),
      .done_o (done_o),
      .idx_o  (idx)
   );

   pdx_bitmove #(.WIDTH(WIDTH), .IDX_W(IDX_W)) move_i (
      .op_i      (op_q),
      .src_i     (src_q),
      .mask_pos_i(pos),
      .pack_idx_i(idx),
      .bit_o     (mv_bit),
      .wr_pos_o  (wr_pos)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         mask_q <= '0;
         res_q  <= '0;
         op_q   <= PDX_SCATTER;
      end else if (load) begin
         src_q  <= src_i;
         mask_q <= mask_i;
         res_q  <= '0;
         op_q   <= pdx_op_e'(op_i);
      end else if (step && any) begin
         mask_q         <= rest;
         res_q[wr_pos]  <= mv_bit;
      end
   end

   assign result_o = res_q;

   AST_ZERO_MASK_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (load && mask_i == '0) |=> ##1 done_o);                              // R4
   AST_MASK_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> ($countones(mask_q) == $past($countones(mask_q)) - 1)); // R5
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i) |=> ($stable(src_q) && $stable(op_q)));            // R7
   AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load) |=> $stable(res_q));                                // R8

endmodule

// File: tb/pdx_unit_tb.sv
module pdx_unit_tb_top;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         op_i = 1'b0;
   logic [W-1:0] src_i = '0;
   logic [W-1:0] mask_i = '0;
   logic [W-1:0] result_o;
   logic         done_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   pdx_unit #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .src_i(src_i), .mask_i(mask_i), .result_o(result_o), .done_o(done_o)
   );

   function automatic logic [W-1:0] ref_op(input logic op, input logic [W-1:0] s, input logic [W-1:0] m);
      logic [W-1:0] r = '0;
      int k = 0;
      for (int p = 0; p < W; p++) begin
         if (m[p]) begin
            if (!op) r[p] = s[k];
            else     r[k] = s[p];
            k++;
         end
      end
      return r;
   endfunction

   function automatic int ref_lat(input logic [W-1:0] m);
      int c = $countones(m);
      return (c == 0) ? 1 : c;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic launch(input logic op, input logic [W-1:0] s, input logic [W-1:0] m);
      @(negedge clk);
      start_i = 1'b1; op_i = op; src_i = s; mask_i = m;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(output int lat);
      lat = 0;
      while (!done_o && lat < W + 8) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic run_check(input logic op, input logic [W-1:0] s, input logic [W-1:0] m, input string req);
      int lat;
      logic [W-1:0] exp;
      logic [W-1:0] got;
      exp = ref_op(op, s, m);
      launch(op, s, m);
      wait_done(lat);
      got = result_o;
      chk(got == exp, req, "result", got, exp);
      chk(lat == ref_lat(m), "R5", "latency", W'(lat), W'(ref_lat(m)));
      @(negedge clk);
      chk(done_o == 1'b0, "R6", "done width", W'(done_o), '0);
   endtask

   task automatic t_reset;
      chk(done_o == 1'b0, "R1", "done after reset", W'(done_o), '0);
      chk(result_o == '0, "R1", "result after reset", result_o, '0);
   endtask

   task automatic t_scatter;   // R2
      run_check(1'b0, 32'h0000_00FF, 32'hF0F0_0F0F, "R2");
      run_check(1'b0, 32'h0000_0055, 32'h8421_8421, "R2");
      run_check(1'b0, 32'hDEAD_BEEF, 32'h8000_0001, "R2");
      run_check(1'b0, 32'hFFFF_FFFF, 32'hAAAA_AAAA, "R4");
   endtask

   task automatic t_gather;    // R3
      run_check(1'b1, 32'h1234_5678, 32'hFF00_00FF, "R3");
      run_check(1'b1, 32'hA5A5_A5A5, 32'h0F0F_F0F0, "R3");
      run_check(1'b1, 32'h8000_0000, 32'h8000_0000, "R3");
      run_check(1'b1, 32'hFFFF_FFFF, 32'h0000_1111, "R4");
   endtask

   task automatic t_zero_mask; // R4
      run_check(1'b0, 32'hFFFF_FFFF, 32'h0, "R4");
      run_check(1'b1, 32'hFFFF_FFFF, 32'h0, "R4");
   endtask

   task automatic t_all_ones;  // R9
      run_check(1'b0, 32'hC0FF_EE11, 32'hFFFF_FFFF, "R9");
      run_check(1'b1, 32'h3141_5926, 32'hFFFF_FFFF, "R9");
   endtask

   task automatic t_busy_start; // R7
      int lat;
      logic [W-1:0] exp;
      exp = ref_op(1'b1, 32'h0F0F_3C3C, 32'h00FF_00F0);
      launch(1'b1, 32'h0F0F_3C3C, 32'h00FF_00F0);
      lat = 0;
      repeat (3) begin @(negedge clk); lat++; end
      start_i = 1'b1; op_i = 1'b0; src_i = 32'hFFFF_FFFF; mask_i = 32'h0000_0003;
      @(negedge clk); lat++;
      start_i = 1'b0;
      while (!done_o && lat < W + 8) begin @(negedge clk); lat++; end
      chk(result_o == exp, "R7", "result after busy start", result_o, exp);
      chk(lat == 12, "R7", "latency after busy start", W'(lat), W'(12));
   endtask

   task automatic t_hold;      // R8
      logic [W-1:0] exp;
      exp = ref_op(1'b0, 32'h0000_0ABC, 32'h0FF0_0F0F);
      run_check(1'b0, 32'h0000_0ABC, 32'h0FF0_0F0F, "R2");
      src_i = '1; mask_i = '1; op_i = 1'b1;
      repeat (5) @(negedge clk);
      chk(result_o == exp, "R8", "result hold", result_o, exp);
      chk(done_o == 1'b0, "R6", "done stays low", W'(done_o), '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_scatter();
      t_gather();
      t_zero_mask();
      t_all_ones();
      t_busy_start();
      t_hold();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule